// File: doc/BRIEF.md
# Streaming Line/Column Parity Code Generator

This block computes a single-error-correcting parity code over a chunk of flash page data. Bytes arrive one per cycle over a valid/ready byte stream. The first byte of a chunk is flagged with a start marker. Each byte is folded into two kinds of running parity:

- **Line parities** come in pairs. For each bit of the byte's position within the chunk, the byte's overall parity goes into one member of the pair, chosen by the value of that index bit.
- **Column parities** are taken from fixed groups of bit lanes inside every byte.

A mode input selects one of two chunk sizes:

- 256-byte chunks give 22 meaningful parity bits.
- 512-byte chunks give 24 parity bits.

A 2048-byte page is covered by running four 512-byte chunks back to back. When the last byte of a chunk has been taken, the block packs the result into three code bytes and pulses a done strobe. The code bytes then hold still until the next chunk starts. A reader later recomputes the code and compares it with the stored code to locate a single flipped bit. That comparison is outside this block.

Top module: `hamming_chunk_parity`

## Requirements
- R1: Byte positions count from 0 at the start-marked byte. For each position bit k in 0..7, the XOR of all eight data bits is folded into line parity LP(2k+1) when position bit k is 1, and into LP(2k) when it is 0.
- R2: In 512-byte mode (`mode512_i`=1 on the start byte), position bit 8 also applies: the byte parity goes into LP17 when the bit is 1 and into LP16 when it is 0. The chunk ends after the byte at position 511.
- R3: The column parities accumulate over the chunk as follows:
  - CP0 is the XOR of bits 6,4,2,0.
  - CP1 is the XOR of bits 7,5,3,1.
  - CP2 is the XOR of bits 5,4,1,0.
  - CP3 is the XOR of bits 7,6,3,2.
  - CP4 is the XOR of bits 3,2,1,0.
  - CP5 is the XOR of bits 7,6,5,4.
- R4: The code bytes are packed as follows:
  - `code0_o` = {LP7..LP0}, MSB first.
  - `code1_o` = {LP15..LP8}.
  - `code2_o` = {CP5,CP4,CP3,CP2,CP1,CP0,LP17,LP16}.
- R5: In 256-byte mode the chunk ends after the byte at position 255, and `code2_o[1:0]` reads 0.
- R6: An accepted byte with `in_start_i`=1 clears all parity state before folding itself in as position 0. This also holds in the middle of an unfinished chunk, which is then abandoned.
- R7: `done_o` is high for exactly one cycle: the cycle after the last byte of a chunk is accepted. The code bytes stay unchanged from then until the next start-marked byte is accepted.
- R8: A byte is ignored when `in_valid_i` is low. A byte is also ignored when it has no start marker and no chunk is open. An ignored byte changes neither the code bytes nor `done_o`.
- R9: While reset is held, `done_o`, `in_ready_o` and all code bytes are 0. After reset is released, `in_ready_o` is 1 in every cycle.
- R10: The chunk size is taken from `mode512_i` on the start-marked byte. Changes to `mode512_i` during the chunk have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode512_i | input | 1 | 1 selects 512-byte chunks, 0 selects 256-byte chunks; sampled on the start byte |
| in_valid_i | input | 1 | Data byte present |
| in_ready_o | output | 1 | Block can accept a byte |
| in_start_i | input | 1 | Marks the first byte of a chunk |
| in_byte_i | input | 8 | Data byte |
| done_o | output | 1 | One-cycle pulse after the last byte of a chunk |
| code0_o | output | 8 | LP7..LP0 |
| code1_o | output | 8 | LP15..LP8 |
| code2_o | output | 8 | CP5..CP0, LP17, LP16 |

## Verification
The bench targets the following corner cases:

- **Lone set bit at a known position.** One set bit at position 300 of a 512-byte chunk gives a fixed, hand-derived code. A swapped pair member or a misordered packing would show as a wrong bit in that code.
- **Chunk length.** Chunks are sent in both modes, with and without bubbles in the valid stream. An off-by-one end index, or one that uses the live mode input instead of the latched one, would pulse done a byte early or late, or never.
- **Restart.** A start marker arrives in the middle of a chunk. A block that fails to clear would mix the old bytes into the new code.
- **Stray bytes.** Stray valid bytes arrive after a chunk has finished. A block that accepted them would corrupt the held code or raise a second done pulse.

// File: rtl/hpar_pkg.sv
package hpar_pkg;

  localparam int BYTE_W = 8;
  localparam int COL_W  = 6;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [COL_W-1:0]  colpar_t;

  // Column contributions of one byte, index c = CPc
  function automatic colpar_t col_terms(input byte_t d);
    colpar_t t;
    t[0] = d[6] ^ d[4] ^ d[2] ^ d[0];
    t[1] = d[7] ^ d[5] ^ d[3] ^ d[1];
    t[2] = d[5] ^ d[4] ^ d[1] ^ d[0];
    t[3] = d[7] ^ d[6] ^ d[3] ^ d[2];
    t[4] = d[3] ^ d[2] ^ d[1] ^ d[0];
    t[5] = d[7] ^ d[6] ^ d[5] ^ d[4];
    return t;
  endfunction

endpackage

// File: rtl/hpar_rst_sync.sv
module hpar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/hpar_sequencer.sv
module hpar_sequencer #(
  parameter int IDX_W     = 9,
  parameter int LONG_LEN  = 512,
  parameter int SHORT_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             start_i,
  input  logic             mode_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             first_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             mode_eff_o,
  output logic             mode_q_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(LONG_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_LEN - 1);

  logic             ready_q, ready_n;
  logic             active_q, active_n;
  logic             mode_q, mode_n;
  logic             done_q, done_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [IDX_W-1:0] idx_use, last_idx;
  logic             mode_use, accept, first, last;

  // next-state
  always_comb begin
    accept   = valid_i && ready_q && (start_i || active_q);
    first    = accept && start_i;
    idx_use  = first ? '0 : idx_q;
    mode_use = first ? mode_i : mode_q;
    last_idx = mode_use ? LAST_LONG : LAST_SHORT;
    last     = accept && (idx_use == last_idx);

    ready_n  = 1'b1;
    active_n = active_q;
    mode_n   = mode_q;
    idx_n    = idx_q;
    done_n   = last;
    if (first) mode_n = mode_i;
    if (accept) begin
      idx_n    = idx_use + 1'b1;
      active_n = !last;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      active_q <= 1'b0;
      mode_q   <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      ready_q  <= ready_n;
      active_q <= active_n;
      mode_q   <= mode_n;
      done_q   <= done_n;
      idx_q    <= idx_n;
    end
  end

  assign ready_o    = ready_q;
  assign accept_o   = accept;
  assign first_o    = first;
  assign idx_o      = idx_use;
  assign mode_eff_o = mode_use;
  assign mode_q_o   = mode_q;
  assign done_o     = done_q;

  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: a finished chunk is closed
  a_r7_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q);
  // R2/R5: the position never passes the last index of the latched mode
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q <= (mode_q ? LAST_LONG : LAST_SHORT)));
  // R10: latched mode changes only on a start byte
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !first |=> $stable(mode_q));
  // R9: ready stays up once out of reset
  a_r9_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);
endmodule

// File: rtl/hpar_line_acc.sv
module hpar_line_acc
  import hpar_pkg::*;
#(
  parameter int PAIRS       = 9,
  parameter int SHORT_PAIRS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic               first_i,
  input  logic               mode_i,
  input  logic [PAIRS-1:0]   idx_i,
  input  byte_t              data_i,
  output logic [2*PAIRS-1:0] lp_o
);
  logic [2*PAIRS-1:0] lp_q, lp_n;
  logic               bpar;

  assign bpar = ^data_i;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    logic use_k, base_hi, base_lo;
    if (k < SHORT_PAIRS) begin : g_always
      assign use_k = 1'b1;
    end else begin : g_long_only
      assign use_k = mode_i;
    end
    assign base_hi = first_i ? 1'b0 : lp_q[2*k+1];
    assign base_lo = first_i ? 1'b0 : lp_q[2*k];
    always_comb begin
      lp_n[2*k+1] = lp_q[2*k+1];
      lp_n[2*k]   = lp_q[2*k];
      if (accept_i) begin
        lp_n[2*k+1] = base_hi ^ (bpar & use_k &  idx_i[k]);
        lp_n[2*k]   = base_lo ^ (bpar & use_k & ~idx_i[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_q <= '0;
    else        lp_q <= lp_n;
  end

  assign lp_o = lp_q;

  // R1: an even-parity byte leaves every line parity untouched
  a_r1_even_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !first_i && !bpar) |=> $stable(lp_q));
  // R1: an odd byte flips exactly one member of each pair it reaches
  a_r1_one_per_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !first_i && bpar && !mode_i) |=>
      ($countones(lp_q ^ $past(lp_q)) == SHORT_PAIRS));
endmodule

// File: rtl/hpar_col_acc.sv
module hpar_col_acc
  import hpar_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept_i,
  input  logic    first_i,
  input  byte_t   data_i,
  output colpar_t cp_o
);
  colpar_t cp_q, cp_n, base;

  always_comb begin
    base = first_i ? '0 : cp_q;
    cp_n = cp_q;
    if (accept_i) cp_n = base ^ col_terms(data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cp_q <= '0;
    else        cp_q <= cp_n;
  end

  assign cp_o = cp_q;

  // R3: a zero byte added to an open chunk leaves the column parities alone
  a_r3_zero_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !first_i && data_i == '0) |=> $stable(cp_q));
endmodule

// File: rtl/hamming_chunk_parity.sv
module hamming_chunk_parity
  import hpar_pkg::*;
#(
  parameter int LONG_LEN  = 512,
  parameter int SHORT_LEN = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode512_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic       in_start_i,
  input  logic [7:0] in_byte_i,
  output logic       done_o,
  output logic [7:0] code0_o,
  output logic [7:0] code1_o,
  output logic [7:0] code2_o
);
  localparam int IDX_W       = $clog2(LONG_LEN);
  localparam int SHORT_PAIRS = $clog2(SHORT_LEN);
  localparam int LP_W        = 2 * IDX_W;

  logic             rst_n_s;
  logic             accept, first, mode_eff, mode_q;
  logic [IDX_W-1:0] idx;
  logic [LP_W-1:0]  lp;
  colpar_t          cp;

  hpar_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  hpar_sequencer #(
    .IDX_W(IDX_W), .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .valid_i(in_valid_i), .start_i(in_start_i), .mode_i(mode512_i),
    .ready_o(in_ready_o), .accept_o(accept), .first_o(first),
    .idx_o(idx), .mode_eff_o(mode_eff), .mode_q_o(mode_q), .done_o(done_o)
  );

  hpar_line_acc #(.PAIRS(IDX_W), .SHORT_PAIRS(SHORT_PAIRS)) u_line (
    .clk(clk), .rst_n(rst_n_s), .accept_i(accept), .first_i(first),
    .mode_i(mode_eff), .idx_i(idx), .data_i(in_byte_i), .lp_o(lp)
  );

  hpar_col_acc u_col (
    .clk(clk), .rst_n(rst_n_s), .accept_i(accept), .first_i(first),
    .data_i(in_byte_i), .cp_o(cp)
  );

  assign code0_o = lp[7:0];
  assign code1_o = lp[15:8];
  assign code2_o = {cp, mode_q ? lp[LP_W-1:LP_W-2] : 2'b00};

  // R7/R8: code bytes move only when a byte is accepted
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    !accept |=> $stable({code0_o, code1_o, code2_o}));
  // R5: short mode leaves the low pair of code2 clear
  a_r5_short_low_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mode_q |-> (code2_o[1:0] == 2'b00));
  // R6: a start byte leaves only its own contribution in the column parity
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (first && in_byte_i == 8'h00) |=> (code2_o[7:2] == 6'b0));
endmodule

// File: tb/hamming_chunk_parity_tb.sv
module hamming_chunk_parity_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode512_i, in_valid_i, in_start_i;
  logic [7:0] in_byte_i;
  logic       in_ready_o, done_o;
  logic [7:0] code0_o, code1_o, code2_o;

  int total = 0;
  int bad   = 0;
  int done_cnt = 0;
  bit finished = 0;
  logic [7:0] mem [0:511];
  logic [7:0] e0, e1, e2;
  int unsigned seed;

  always #5 clk = ~clk;

  hamming_chunk_parity u_dut (
    .clk(clk), .rst_n(rst_n), .mode512_i(mode512_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_start_i(in_start_i),
    .in_byte_i(in_byte_i), .done_o(done_o),
    .code0_o(code0_o), .code1_o(code1_o), .code2_o(code2_o)
  );

  always @(negedge clk) if (done_o) done_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference code from the requirement text
  task automatic ref_code(input bit m512, input int n);
    logic [17:0] lp;
    logic [5:0]  cp;
    lp = '0; cp = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      logic p;
      d = mem[i];
      p = ^d;
      for (int k = 0; k < (m512 ? 9 : 8); k++) begin
        if ((i >> k) & 1) lp[2*k+1] ^= p;
        else              lp[2*k]   ^= p;
      end
      cp[0] ^= d[6]^d[4]^d[2]^d[0];
      cp[1] ^= d[7]^d[5]^d[3]^d[1];
      cp[2] ^= d[5]^d[4]^d[1]^d[0];
      cp[3] ^= d[7]^d[6]^d[3]^d[2];
      cp[4] ^= d[3]^d[2]^d[1]^d[0];
      cp[5] ^= d[7]^d[6]^d[5]^d[4];
    end
    e0 = lp[7:0];
    e1 = lp[15:8];
    e2 = {cp, m512 ? lp[17:16] : 2'b00};
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < 512; i++) begin
      case (kind)
        0: mem[i] = 8'h00;
        1: mem[i] = 8'(i * 3 + 1);
        default: begin
          seed = seed * 1103515245 + 12345;
          mem[i] = seed[23:16];
        end
      endcase
    end
  endtask

  // Drive n bytes starting with a start marker; optional bubbles and mode toggling
  task automatic drive(input bit m512, input int n, input bit gaps, input bit wiggle);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        in_valid_i = 1'b0;
        in_start_i = 1'b0;
      end
      @(negedge clk);
      in_valid_i = 1'b1;
      in_start_i = (i == 0);
      in_byte_i  = mem[i];
      mode512_i  = (wiggle && i > 0) ? ~m512 : m512;
    end
  endtask

  task automatic run_chunk(string req, input bit m512, input bit gaps, input bit wiggle);
    int n, d0;
    n = m512 ? 512 : 256;
    ref_code(m512, n);
    d0 = done_cnt;
    drive(m512, n, gaps, wiggle);
    @(negedge clk);
    in_valid_i = 1'b0;
    in_start_i = 1'b0;
    mode512_i  = m512;
    chk({req, " done pulse"}, done_o, 1);
    chk({req, " code0"}, code0_o, e0);
    chk({req, " code1"}, code1_o, e1);
    chk({req, " code2"}, code2_o, e2);
    @(negedge clk);
    chk("R7 done low after pulse", done_o, 0);
    chk("R7 single done per chunk", done_cnt - d0, 1);
    chk("R7 code held", {code0_o, code1_o, code2_o}, {e0, e1, e2});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    mode512_i = 0; in_valid_i = 0; in_start_i = 0; in_byte_i = 0;
    repeat (3) @(negedge clk);
    chk("R9 done in reset", done_o, 0);
    chk("R9 ready in reset", in_ready_o, 0);
    chk("R9 codes in reset", {code0_o, code1_o, code2_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 ready after reset", in_ready_o, 1);
    chk("R9 done after reset", done_o, 0);
  endtask

  task automatic t_lone_bit;
    // R2/R4: bit 5 of position 300 in a 512-byte chunk
    fill(0);
    mem[300] = 8'h20;
    run_chunk("R2 lone bit", 1'b1, 1'b0, 1'b0);
    chk("R4 lone bit code0", code0_o, 8'hA5);
    chk("R4 lone bit code1", code1_o, 8'h59);
    chk("R2 lone bit code2", code2_o, 8'h9A);
  endtask

  task automatic t_idle_bytes;
    logic [23:0] held;
    int d0;
    held = {code0_o, code1_o, code2_o};
    d0 = done_cnt;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid_i = 1'b1;
      in_start_i = 1'b0;
      in_byte_i  = 8'(8'hF1 + i);
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 stray bytes keep code", {code0_o, code1_o, code2_o}, held);
    chk("R8 stray bytes no done", done_cnt - d0, 0);
  endtask

  task automatic t_restart;
    // R6: abandon a partial chunk with a new start marker
    fill(1);
    drive(1'b1, 100, 1'b0, 1'b0);
    @(negedge clk);
    in_valid_i = 1'b0;
    seed = 32'h1234;
    fill(2);
    run_chunk("R6 restart", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    seed = 32'hC0FFEE;
    t_reset();
    fill(0);
    run_chunk("R1 zero 256", 1'b0, 1'b0, 1'b0);
    fill(1);
    run_chunk("R1 ramp 256", 1'b0, 1'b0, 1'b0);
    fill(2);
    run_chunk("R5 random 256 gaps", 1'b0, 1'b1, 1'b0);
    fill(2);
    run_chunk("R3 random 512", 1'b1, 1'b0, 1'b0);
    t_lone_bit();
    t_idle_bytes();
    t_restart();
    fill(2);
    run_chunk("R10 mode toggled 256", 1'b0, 1'b0, 1'b1);
    fill(2);
    run_chunk("R10 mode toggled 512", 1'b1, 1'b1, 1'b1);
    for (int q = 0; q < 4; q++) begin
      fill(2);
      run_chunk("R2 page quarter", 1'b1, 1'b0, 1'b0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule